// File: doc/BRIEF.md
# SPI Flash Read-Command Responder

This block is an SPI target that answers the serial-flash read command from a small internal byte array. A host lowers chip-select and shifts in an 8-bit opcode followed by a 24-bit byte address, MSB first. When the opcode is the read code, the block streams bytes out starting at that address. The address moves up by one after each byte and returns to zero after the top of the array. The stream has no length limit and stops only when chip-select goes high.

The block runs on a local system clock. Chip-select, SCK and SI pass through synchronizers, and SCK edges are detected in the clock domain, so SCK must run well below the system clock. The serial output comes with a separate output-enable; while that enable is low the line counts as high impedance. A synchronous write port lets a bench or a loader fill the array before reads. The depth of the array is set by a parameter, and that depth also sets where the address wraps.

Top module: `spi_flash_rd`

## Requirements
- R1: SI is sampled on rising SCK edges while cs_ni is low. The first 8 bits form the opcode and the next 24 bits form the address, both MSB first. The read opcode is 0x03.
- R2: so_oe_o is low after reset and during all 32 opcode and address clocks.
- R3: On the falling SCK edge after the 32nd rising edge, so_oe_o rises and so_o carries bit 7 of the addressed byte. Each falling edge after that presents the next bit, MSB first. so_o is settled within 4 clk_i cycles of the falling edge and holds between falling edges.
- R4: While cs_ni stays low, bytes follow at consecutive addresses with no length limit.
- R5: After the byte at address 2^ADDR_W-1, the stream continues at address 0.
- R6: Address bits at positions ADDR_W and above are ignored, so only the low ADDR_W bits select the start byte.
- R7: If the opcode is anything other than 0x03, so_oe_o stays low for every following clock until cs_ni rises.
- R8: A rise of cs_ni ends a read at any bit. so_oe_o is low within 4 clk_i cycles, and the next cs_ni low period starts again with a fresh opcode.
- R9: Both SCK idle levels are accepted: SCK may be low (mode 0) or high (mode 3) when cs_ni falls.
- R10: When wr_en_i is high on a rising clk_i edge, wr_data_i is stored at wr_addr_i. Later reads of that address return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | SPI chip-select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (low means high impedance) |
| wr_en_i | input | 1 | Array write strobe |
| wr_addr_i | input | ADDR_W | Array write address |
| wr_data_i | input | 8 | Array write data |

## Verification
Inside the block, an SCK edge reaches the output registers after two synchronizer stages and one edge-detect register. so_o and so_oe_o are therefore due 3 clk_i cycles after the edge, and 4 cycles is the stated bound. The bench holds each SCK phase for 8 clk_i cycles. Its monitor samples so_o on the next rising SCK, which is 8 cycles after the falling edge that launched the bit, so it never samples inside the settling window. After a chip-select rise, the bench waits 6 cycles before it checks that the enable has dropped.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } rd_state_e;

  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int         OP_BITS   = 8;
  localparam int         CMD_BITS  = 32;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic              last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= {STAGES{RST_VAL[g]}};
        last_q <= RST_VAL[g];
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
        last_q <= pipe_q[STAGES-1];
      end
    end
    assign q_o[g]    = pipe_q[STAGES-1];
    assign rise_o[g] = pipe_q[STAGES-1] & ~last_q;
    assign fall_o[g] = ~pipe_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  p_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_hi_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              si_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              so_o,
  output logic              so_oe_o
);
  localparam int CNT_W = $clog2(CMD_BITS);

  rd_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [6:0]        op_sr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [6:0]        out_sr_q;
  logic [2:0]        bit_q;
  logic              so_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CMD;
      cnt_q    <= '0;
      op_sr_q  <= '0;
      addr_q   <= '0;
      out_sr_q <= '0;
      bit_q    <= '0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else if (cs_hi_i) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      bit_q   <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (sck_rise_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < CNT_W'(OP_BITS - 1)) op_sr_q <= {op_sr_q[5:0], si_i};
          else if (cnt_q > CNT_W'(OP_BITS - 1)) addr_q <= {addr_q[ADDR_W-2:0], si_i};
          if (cnt_q == CNT_W'(OP_BITS - 1) && {op_sr_q, si_i} != RD_OPCODE)
            state_q <= ST_SKIP;
          if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end
        end
        ST_DATA: if (sck_fall_i) begin
          oe_q  <= 1'b1;
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd0) begin
            so_q     <= rd_data_i[7];
            out_sr_q <= rd_data_i[6:0];
            addr_q   <= addr_q + 1'b1;  // wraps at the array top
          end else begin
            so_q     <= out_sr_q[6];
            out_sr_q <= {out_sr_q[5:0], 1'b0};
          end
        end
        default: ;  // ST_SKIP: wait for chip-select release
      endcase
    end
  end

  assign rd_addr_o = addr_q;
  assign so_o      = so_q;
  assign so_oe_o   = oe_q;

  p_enter_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_hi_i && state_q == ST_CMD && sck_rise_i && cnt_q == CNT_W'(CMD_BITS - 1))
      |=> state_q == ST_DATA);
  p_quiet_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DATA) |-> !oe_q);
  p_so_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !sck_fall_i && !cs_hi_i) |=> $stable(so_q));
  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_hi_i && state_q == ST_DATA && sck_fall_i && bit_q == 3'd0)
      |=> addr_q == $past(addr_q) + 1'b1);
  p_skip_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP && !cs_hi_i) |=> state_q == ST_SKIP);
  p_cs_drops_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |=> !oe_q);
endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i
);
  // bit 0: cs_ni, bit 1: sck_i, bit 2: si_i
  logic [2:0] pin_q, pin_rise, pin_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  spi_rd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({si_i, sck_i, cs_ni}),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  spi_rd_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  spi_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_hi_i    (pin_q[0]),
    .sck_rise_i (pin_rise[1]),
    .sck_fall_i (pin_fall[1]),
    .si_i       (pin_q[2]),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  logic unused_edges;
  assign unused_edges = ^{pin_rise[0], pin_fall[0], pin_rise[2], pin_fall[2]};
endmodule

// File: tb/spi_flash_rd_test.sv
module spi_flash_rd_test;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int H      = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, si_i = 1'b0;
  logic so_o, so_oe_o;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;

  always #4 clk = ~clk;  // 125 MHz

  spi_flash_rd #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .si_i(si_i),
    .so_o(so_o), .so_oe_o(so_oe_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string exp_tag [$];
  bit rx_en = 1'b0, quiet = 1'b0;
  string quiet_tag = "R2";
  int mon_bits = 0;
  logic [7:0] mon_sh = '0;
  bit mon_oe_ok = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: samples on rising SCK, 8 clk cycles after the launching fall
  always @(posedge sck_i) begin
    if (quiet) chk(so_oe_o == 1'b0, quiet_tag, so_oe_o, 0);
    if (rx_en) begin
      mon_sh    = {mon_sh[6:0], so_o};
      mon_oe_ok = mon_oe_ok & so_oe_o;
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) chk(1'b0, "R4 extra byte", mon_sh, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = exp_tag.pop_front();
          chk(mon_sh == e && mon_oe_ok, t, {mon_oe_ok, mon_sh}, {1'b1, e});
        end
        mon_oe_ok = 1'b1;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic d);
    sck_i = 1'b0;
    si_i  = d;
    wait_clk(H);
    sck_i = 1'b1;
    wait_clk(H);
  endtask

  // driver: full transaction, pushes expected bytes into the scoreboard
  task automatic rd(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                    input int extra_bits, input bit mode3, input string tag,
                    input bit abort_chk);
    logic [31:0] cmd;
    cmd = {op, a};
    sck_i = mode3;
    wait_clk(H);
    mon_bits  = 0;
    mon_oe_ok = 1'b1;
    cs_ni = 1'b0;
    quiet_tag = "R2 oe during command";
    quiet = 1'b1;
    wait_clk(H);
    for (int i = 31; i >= 0; i--) bit_clk(cmd[i]);
    quiet = 1'b0;
    if (op == 8'h03) begin
      for (int k = 0; k < nbytes; k++) begin
        exp_q.push_back(model[(int'(a) + k) % DEPTH]);
        exp_tag.push_back(tag);
      end
      rx_en = 1'b1;
      for (int i = 0; i < nbytes * 8 + extra_bits; i++) bit_clk(1'b0);
      rx_en = 1'b0;
    end else begin
      quiet_tag = "R7 oe after bad opcode";
      quiet = 1'b1;
      for (int i = 0; i < 16; i++) bit_clk(1'b0);
      quiet = 1'b0;
    end
    sck_i = mode3;
    wait_clk(H);
    cs_ni = 1'b1;
    wait_clk(6);
    if (abort_chk) chk(so_oe_o == 1'b0, "R8 oe after chip-select rise", so_oe_o, 0);
    wait_clk(2 * H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    chk(so_oe_o == 1'b0, "R2 reset oe", so_oe_o, 0);
    rst_ni = 1'b1;
    wait_clk(2);
    // R10: preload through the write port
    for (int i = 0; i < DEPTH; i++) begin
      model[i]  = 8'((i * 37 + 11) ^ (i >> 3));
      wr_en_i   = 1'b1;
      wr_addr_i = ADDR_W'(i);
      wr_data_i = model[i];
      wait_clk(1);
    end
    wr_en_i = 1'b0;
    wait_clk(4);

    rd(8'h03, 24'h000010, 6, 0, 1'b0, "R1 R3 R4 R10 mode0 stream", 1'b1);
    rd(8'h03, 24'h000080, 4, 0, 1'b1, "R9 mode3 stream", 1'b1);
    rd(8'h03, 24'(DEPTH - 3), 6, 0, 1'b0, "R5 wrap to zero", 1'b0);
    rd(8'h03, 24'h5A3C21, 3, 0, 1'b1, "R6 high address bits", 1'b0);
    rd(8'h0B, 24'h000010, 0, 0, 1'b0, "R7", 1'b1);
    rd(8'h03, 24'h000040, 2, 3, 1'b0, "R8 aborted read", 1'b1);
    rd(8'h03, 24'h000041, 2, 0, 1'b0, "R8 fresh command after abort", 1'b0);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule